// File: doc/BRIEF.md
# Variable Precision Multiply-Accumulate Slice

This block is a pipelined fixed-point arithmetic slice meant to be tiled in rows for filters and dot products. Static configuration inputs pick its shape. In narrow mode it runs two signed 18x19 multiplies side by side. In wide mode it runs one 27x27 multiply. Every multiplier has an adder/subtractor on its data input. Every multiplier can also take its coefficient from a small parameter-defined bank instead of the live coefficient input.

The products reach a 64-bit output stage. That stage can add or subtract the two narrow products. It can also keep them apart as two 32-bit halves, which serve as separate I and Q running sums. The stage can add the previous result back in, and it always adds a 64-bit cascade input from a neighbouring slice. The registered result drives the cascade output to the next slice. For systolic chains, one extra register can be placed on the cascade input so that chained slices stay aligned.

Every path is three registers deep: input, product and output.

Top module: `vmac_slice`

## Requirements
- R1: When `rst_n` is low, or `clr` is high at a clock edge, every register is zeroed and `result` reads 0 after that edge. `clr` takes effect even when `en` is low.
- R2: An operand set presented before edge k appears on `result` after edge k+2, which is three edges counting the capture. `casc_out` always equals `result`.
- R3: With `wide_mode`=0, lane i computes (ai op bi) * ci on 18-bit pre-adder operands and an 18-bit coefficient. With `split_acc`=0 the stage adds lane1 to lane0 when `lane_sub`=0 and subtracts lane1 from lane0 when `lane_sub`=1, in 64-bit two's complement.
- R4: With `wide_mode`=1 the result is (wa op wb) * wc on 26-bit pre-adder operands and a 27-bit coefficient. The lane inputs have no effect.
- R5: With `pre_en`=1 the pre-adder forms a+b when `pre_sub`=0 and a-b when `pre_sub`=1. With `pre_en`=0 only a enters the multiplier and b has no effect.
- R6: When `coef_use[i]`=1, lane i takes the bank entry chosen by its select instead of its live coefficient. Bank entry n sits at bits [27n+26:27n] of `COEF_BANK`. Narrow lanes use the low 18 bits of the entry and the wide multiplier uses all 27 bits. The wide multiplier uses `coef_use[0]` and `coef_sel0`.
- R7: `sgn_pre`=1 sign-extends the pre-adder operands and 0 zero-extends them. `sgn_coef` does the same for the coefficient.
- R8: With `acc_en`=1 and `acc_load`=0, the previous `result` is added to the new sum. With `acc_load`=1 or `acc_en`=0 the feedback term is zero. The 64-bit sum wraps modulo 2^64.
- R9: With `wide_mode`=0 and `split_acc`=1, bits 31:0 carry lane0's running sum and bits 63:32 carry lane1's. Each half takes its part of the feedback and of the cascade, wraps modulo 2^32, and never carries into the other half.
- R10: `casc_in` is added into the output stage. With `sys_en`=0 a value present before edge k is added at edge k. With `sys_en`=1 it passes through one extra register and is added one edge later.
- R11: While `en` is low and `clr` is low, all registers hold and input changes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of all pipeline state |
| en | input | 1 | Clock enable for all registers |
| wide_mode | input | 1 | 1: single 27x27, 0: dual 18x19 |
| split_acc | input | 1 | Dual mode: two independent 32-bit halves |
| lane_sub | input | 1 | Dual non-split: subtract lane1 from lane0 |
| sys_en | input | 1 | Insert systolic register on the cascade input |
| pre_en | input | 1 | Enable pre-adder |
| sgn_pre | input | 1 | Pre-adder operands are signed |
| sgn_coef | input | 1 | Coefficients are signed |
| pre_sub | input | 1 | Pre-adder subtracts (per sample) |
| acc_en | input | 1 | Add previous result (per sample) |
| acc_load | input | 1 | Start a new sum: zero feedback (per sample) |
| coef_use | input | 2 | Per lane: take coefficient from bank |
| coef_sel0 | input | 3 | Bank entry for lane 0 / wide multiplier |
| coef_sel1 | input | 3 | Bank entry for lane 1 |
| a0 | input | 18 | Lane 0 pre-adder operand a |
| b0 | input | 18 | Lane 0 pre-adder operand b |
| c0 | input | 18 | Lane 0 live coefficient |
| a1 | input | 18 | Lane 1 pre-adder operand a |
| b1 | input | 18 | Lane 1 pre-adder operand b |
| c1 | input | 18 | Lane 1 live coefficient |
| wa | input | 26 | Wide pre-adder operand a |
| wb | input | 26 | Wide pre-adder operand b |
| wc | input | 27 | Wide live coefficient |
| casc_in | input | 64 | Cascade input from the previous slice |
| result | output | 64 | Registered result |
| casc_out | output | 64 | Cascade output to the next slice |

## Verification
A wrong internal state shows up within three cycles as a wrong `result`, because every path through the slice is exactly three registers deep. A fault in the feedback path is different. The wrong value is added back on every following sample, so the error persists and grows until the next accumulate-load. A misaligned control pipeline shows as a sum that starts or stops one sample early. A carry leaking between the split halves shows only when the low half wraps, so the bench drives lane products larger than 2^32.

// File: rtl/vmac_pkg.sv
// Shared constants and types for the multiply-accumulate slice.
package vmac_pkg;
    localparam int ACC_W  = 64;
    localparam int HALF_W = ACC_W / 2;

    // Per-sample accumulator controls that travel with the data.
    typedef struct packed {
        logic acc_en;
        logic acc_load;
    } acc_ctl_t;
endpackage

// File: rtl/vmac_lane.sv
// One multiplier lane: input register, pre-adder, coefficient choice,
// signed multiply and the pipeline register after the multiplier.
// Assumes the static controls (pre_en, sgn_*) are stable while data flows.
module vmac_lane #(
    parameter int AW    = 18,
    parameter int CW    = 18,
    parameter int BW    = 27,
    parameter int NCOEF = 8,
    parameter int SEL_W = $clog2(NCOEF),
    parameter logic [NCOEF*BW-1:0] BANK = '0,
    localparam int PW   = AW + CW + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 pre_en,
    input  logic                 sgn_pre,
    input  logic                 sgn_coef,
    input  logic [AW-1:0]        a,
    input  logic [AW-1:0]        b,
    input  logic [CW-1:0]        c,
    input  logic                 pre_sub,
    input  logic                 coef_use,
    input  logic [SEL_W-1:0]     coef_sel,
    output logic signed [PW-1:0] prod
);
    logic [AW-1:0]    a_q, b_q;
    logic [CW-1:0]    c_q;
    logic             sub_q, use_q;
    logic [SEL_W-1:0] sel_q;
    logic [AW+1:0]    ax, bx, pre_v;
    logic [CW-1:0]    cq;
    logic [CW:0]      cx;
    logic signed [PW-1:0] mul_v;

    // Input register stage.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            a_q <= '0; b_q <= '0; c_q <= '0;
            sub_q <= 1'b0; use_q <= 1'b0; sel_q <= '0;
        end else if (en) begin
            a_q <= a; b_q <= b; c_q <= c;
            sub_q <= pre_sub; use_q <= coef_use; sel_q <= coef_sel;
        end
    end

    // Extend operands, pre-add and pick the coefficient.
    always_comb begin
        ax = sgn_pre ? {{2{a_q[AW-1]}}, a_q} : {2'b00, a_q};
        bx = sgn_pre ? {{2{b_q[AW-1]}}, b_q} : {2'b00, b_q};
        if (!pre_en)     pre_v = ax;
        else if (sub_q)  pre_v = ax - bx;
        else             pre_v = ax + bx;
        cq = use_q ? BANK[sel_q*BW +: CW] : c_q;
        cx = sgn_coef ? {cq[CW-1], cq} : {1'b0, cq};
        mul_v = $signed(pre_v) * $signed(cx);
    end

    // Pipeline register after the multiplier.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) prod <= '0;
        else if (en)       prod <= mul_v;
    end
endmodule

// File: rtl/vmac_accum.sv
// Output stage: combines products, adds feedback and cascade, registers
// the result. Holds the optional systolic register on the cascade input.
module vmac_accum
    import vmac_pkg::*;
#(
    parameter int LPW = 39,
    parameter int WPW = 56
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  en,
    input  logic                  wide_mode,
    input  logic                  split_acc,
    input  logic                  lane_sub,
    input  logic                  sys_en,
    input  logic                  fb_on,
    input  logic signed [LPW-1:0] p0,
    input  logic signed [LPW-1:0] p1,
    input  logic signed [WPW-1:0] pw,
    input  logic [ACC_W-1:0]      casc_in,
    output logic [ACC_W-1:0]      result
);
    logic [ACC_W-1:0]  casc_q, cas, fb, s0, s1, sw, nxt;
    logic [HALF_W-1:0] lo, hi;

    // Systolic delay register on the cascade input.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) casc_q <= '0;
        else if (en)       casc_q <= casc_in;
    end

    // Form the next result in full or split arithmetic.
    always_comb begin
        cas = sys_en ? casc_q : casc_in;
        fb  = fb_on ? result : '0;
        s0  = {{(ACC_W-LPW){p0[LPW-1]}}, p0};
        s1  = {{(ACC_W-LPW){p1[LPW-1]}}, p1};
        sw  = {{(ACC_W-WPW){pw[WPW-1]}}, pw};
        lo  = s0[HALF_W-1:0] + fb[HALF_W-1:0] + cas[HALF_W-1:0];
        hi  = s1[HALF_W-1:0] + fb[ACC_W-1:HALF_W] + cas[ACC_W-1:HALF_W];
        if (wide_mode)      nxt = sw + fb + cas;
        else if (split_acc) nxt = {hi, lo};
        else if (lane_sub)  nxt = s0 - s1 + fb + cas;
        else                nxt = s0 + s1 + fb + cas;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) result <= '0;
        else if (en)       result <= nxt;
    end
endmodule

// File: rtl/vmac_slice.sv
// Top of the multiply-accumulate slice: two narrow lanes, one wide lane,
// per-sample control alignment and the output stage.
// Assumes static configuration changes only around a clear.
module vmac_slice
    import vmac_pkg::*;
#(
    parameter int LANE_AW = 18,
    parameter int LANE_CW = 18,
    parameter int WIDE_AW = 26,
    parameter int WIDE_CW = 27,
    parameter int NCOEF   = 8,
    parameter logic [NCOEF*WIDE_CW-1:0] COEF_BANK = {
        27'd5, 27'h3FFFFFF, 27'd77, 27'h0020001,
        27'd1000, 27'h4000000, 27'h7FFFFFF, 27'd3},
    localparam int SEL_W   = $clog2(NCOEF),
    localparam int LANE_PW = LANE_AW + LANE_CW + 3,
    localparam int WIDE_PW = WIDE_AW + WIDE_CW + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic               wide_mode,
    input  logic               split_acc,
    input  logic               lane_sub,
    input  logic               sys_en,
    input  logic               pre_en,
    input  logic               sgn_pre,
    input  logic               sgn_coef,
    input  logic               pre_sub,
    input  logic               acc_en,
    input  logic               acc_load,
    input  logic [1:0]         coef_use,
    input  logic [SEL_W-1:0]   coef_sel0,
    input  logic [SEL_W-1:0]   coef_sel1,
    input  logic [LANE_AW-1:0] a0,
    input  logic [LANE_AW-1:0] b0,
    input  logic [LANE_CW-1:0] c0,
    input  logic [LANE_AW-1:0] a1,
    input  logic [LANE_AW-1:0] b1,
    input  logic [LANE_CW-1:0] c1,
    input  logic [WIDE_AW-1:0] wa,
    input  logic [WIDE_AW-1:0] wb,
    input  logic [WIDE_CW-1:0] wc,
    input  logic [ACC_W-1:0]   casc_in,
    output logic [ACC_W-1:0]   result,
    output logic [ACC_W-1:0]   casc_out
);
    logic [LANE_AW-1:0] la [2];
    logic [LANE_AW-1:0] lb [2];
    logic [LANE_CW-1:0] lc [2];
    logic [SEL_W-1:0]   lsel [2];
    logic signed [LANE_PW-1:0] prod_l [2];
    logic signed [WIDE_PW-1:0] prod_w;
    acc_ctl_t ctl_s1, ctl_s2;
    logic     fb_on;

    assign la[0] = a0;  assign la[1] = a1;
    assign lb[0] = b0;  assign lb[1] = b1;
    assign lc[0] = c0;  assign lc[1] = c1;
    assign lsel[0] = coef_sel0;  assign lsel[1] = coef_sel1;

    // Two narrow lanes of identical structure.
    for (genvar gi = 0; gi < 2; gi++) begin : g_lane
        vmac_lane #(
            .AW(LANE_AW), .CW(LANE_CW), .BW(WIDE_CW),
            .NCOEF(NCOEF), .BANK(COEF_BANK)
        ) u_lane (
            .clk(clk), .rst_n(rst_n), .clr(clr), .en(en),
            .pre_en(pre_en), .sgn_pre(sgn_pre), .sgn_coef(sgn_coef),
            .a(la[gi]), .b(lb[gi]), .c(lc[gi]),
            .pre_sub(pre_sub), .coef_use(coef_use[gi]),
            .coef_sel(lsel[gi]), .prod(prod_l[gi])
        );
    end

    // Wide lane.
    vmac_lane #(
        .AW(WIDE_AW), .CW(WIDE_CW), .BW(WIDE_CW),
        .NCOEF(NCOEF), .BANK(COEF_BANK)
    ) u_wide (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en),
        .pre_en(pre_en), .sgn_pre(sgn_pre), .sgn_coef(sgn_coef),
        .a(wa), .b(wb), .c(wc),
        .pre_sub(pre_sub), .coef_use(coef_use[0]),
        .coef_sel(coef_sel0), .prod(prod_w)
    );

    // Delay accumulator controls to meet the products at the output stage.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ctl_s1 <= '0;
            ctl_s2 <= '0;
        end else if (en) begin
            ctl_s1 <= '{acc_en: acc_en, acc_load: acc_load};
            ctl_s2 <= ctl_s1;
        end
    end

    assign fb_on = ctl_s2.acc_en & ~ctl_s2.acc_load;

    vmac_accum #(.LPW(LANE_PW), .WPW(WIDE_PW)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en),
        .wide_mode(wide_mode), .split_acc(split_acc),
        .lane_sub(lane_sub), .sys_en(sys_en), .fb_on(fb_on),
        .p0(prod_l[0]), .p1(prod_l[1]), .pw(prod_w),
        .casc_in(casc_in), .result(result)
    );

    assign casc_out = result;
endmodule

// File: rtl/vmac_slice_chk.sv
// Checker for the slice: relates the product registers, the control
// pipeline and the output register across one clock.
module vmac_slice_chk #(
    parameter int ACC_W = 64,
    parameter int WPW   = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             en,
    input logic             wide_mode,
    input logic             split_acc,
    input logic             sys_en,
    input logic             fb_on,
    input logic [31:0]      prod0_lo,
    input logic [31:0]      prod1_lo,
    input logic [WPW-1:0]   prodw,
    input logic [ACC_W-1:0] casc_in,
    input logic [ACC_W-1:0] result
);
    logic [ACC_W-1:0] pw_ext;
    logic             quiet;
    assign pw_ext = {{(ACC_W-WPW){prodw[WPW-1]}}, prodw};
    assign quiet  = en && !clr && !sys_en && (casc_in == '0) && !fb_on;

    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (result == '0));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(result));

    p_prod_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> ($stable(prodw) && $stable(prod0_lo) && $stable(prod1_lo)));

    p_split_halves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !wide_mode && split_acc) |=>
        (result[31:0] == $past(prod0_lo) && result[63:32] == $past(prod1_lo)));

    p_wide_product_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && wide_mode) |=> (result == $past(pw_ext)));
endmodule

bind vmac_slice vmac_slice_chk #(.ACC_W(64), .WPW(WIDE_PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en),
    .wide_mode(wide_mode), .split_acc(split_acc), .sys_en(sys_en),
    .fb_on(fb_on), .prod0_lo(prod_l[0][31:0]), .prod1_lo(prod_l[1][31:0]),
    .prodw(prod_w), .casc_in(casc_in), .result(result)
);

// File: tb/sim_vmac_slice.sv
// Directed bench for the multiply-accumulate slice with a reference model.
module sim_vmac_slice;
    localparam logic [8*27-1:0] BANK = {
        27'd5, 27'h3FFFFFF, 27'd77, 27'h0020001,
        27'd1000, 27'h4000000, 27'h7FFFFFF, 27'd3};

    logic clk = 1'b0;
    logic rst_n, clr, en, wide_mode, split_acc, lane_sub, sys_en;
    logic pre_en, sgn_pre, sgn_coef, pre_sub, acc_en, acc_load;
    logic [1:0]  coef_use;
    logic [2:0]  coef_sel0, coef_sel1;
    logic [17:0] a0, b0, c0, a1, b1, c1;
    logic [25:0] wa, wb;
    logic [26:0] wc;
    logic [63:0] casc_in, result, casc_out;

    int n_chk = 0, n_fail = 0, ticks = 0, wr = 0, rd = 0;
    bit done = 0;
    string cur_req = "R0";
    logic [63:0] m_acc;
    logic [63:0] exp_q [0:255];
    int          due_q [0:255];

    always #5 clk = ~clk;

    vmac_slice #(.COEF_BANK(BANK)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en),
        .wide_mode(wide_mode), .split_acc(split_acc), .lane_sub(lane_sub),
        .sys_en(sys_en), .pre_en(pre_en), .sgn_pre(sgn_pre),
        .sgn_coef(sgn_coef), .pre_sub(pre_sub), .acc_en(acc_en),
        .acc_load(acc_load), .coef_use(coef_use), .coef_sel0(coef_sel0),
        .coef_sel1(coef_sel1), .a0(a0), .b0(b0), .c0(c0), .a1(a1),
        .b1(b1), .c1(c1), .wa(wa), .wb(wb), .wc(wc), .casc_in(casc_in),
        .result(result), .casc_out(casc_out)
    );

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
    end

    task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic longint ext(longint v, int w, bit s);
        longint m = (longint'(1) << w) - 1;
        longint x = v & m;
        if (s && x[w-1]) return x - (longint'(1) << w);
        return x;
    endfunction

    function automatic longint lane_prod(longint a, longint b, longint c,
                                         int aw, int cw, bit use_b, int sel);
        longint ea = ext(a, aw, sgn_pre);
        longint eb = ext(b, aw, sgn_pre);
        longint pre = !pre_en ? ea : (pre_sub ? ea - eb : ea + eb);
        longint raw = use_b ? longint'(BANK[sel*27 +: 27]) : c;
        return pre * ext(raw, cw, sgn_coef);
    endfunction

    // Reference model for the sample now on the inputs.
    task automatic commit();
        longint p0, p1, pw;
        logic [63:0] fb, r;
        logic [31:0] lo, hi;
        fb = (acc_en && !acc_load) ? m_acc : 64'd0;
        if (wide_mode) begin
            pw = lane_prod(wa, wb, wc, 26, 27, coef_use[0], int'(coef_sel0));
            r = 64'(pw) + fb + casc_in;
        end else begin
            p0 = lane_prod(a0, b0, c0, 18, 18, coef_use[0], int'(coef_sel0));
            p1 = lane_prod(a1, b1, c1, 18, 18, coef_use[1], int'(coef_sel1));
            if (split_acc) begin
                lo = 32'(p0) + fb[31:0] + casc_in[31:0];
                hi = 32'(p1) + fb[63:32] + casc_in[63:32];
                r = {hi, lo};
            end else if (lane_sub) r = 64'(p0 - p1) + fb + casc_in;
            else                   r = 64'(p0 + p1) + fb + casc_in;
        end
        m_acc = r;
        exp_q[wr] = r; due_q[wr] = ticks + 3; wr++;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
        ticks++;
        while (rd < wr && due_q[rd] == ticks) begin
            check64(cur_req, result, exp_q[rd]);
            rd++;
        end
    endtask

    task automatic zero_data();
        a0 = 0; b0 = 0; c0 = 0; a1 = 0; b1 = 0; c1 = 0;
        wa = 0; wb = 0; wc = 0; coef_use = 0; coef_sel0 = 0; coef_sel1 = 0;
        pre_sub = 0; acc_en = 0; acc_load = 0;
    endtask

    task automatic cfg(bit w, bit sp, bit ls, bit sy, bit pe, bit sa, bit sc);
        wide_mode = w; split_acc = sp; lane_sub = ls; sys_en = sy;
        pre_en = pe; sgn_pre = sa; sgn_coef = sc;
    endtask

    task automatic clear_run();
        zero_data();
        clr = 1; en = 1;
        @(posedge clk); @(negedge clk);
        clr = 0; ticks = 0; wr = 0; rd = 0; m_acc = casc_in;
    endtask

    task automatic dsmp(logic [17:0] xa0, logic [17:0] xb0, logic [17:0] xc0,
                        logic [17:0] xa1, logic [17:0] xb1, logic [17:0] xc1,
                        bit ps);
        a0 = xa0; b0 = xb0; c0 = xc0; a1 = xa1; b1 = xb1; c1 = xc1;
        wa = 26'h155AAAA; wb = 26'h0F0F0F0; wc = 27'h1234567; pre_sub = ps;
        commit(); tick();
    endtask

    task automatic wsmp(logic [25:0] xa, logic [25:0] xb, logic [26:0] xc, bit ps);
        wa = xa; wb = xb; wc = xc; pre_sub = ps;
        a0 = 18'h12345; b0 = 18'h2AAAA; c0 = 18'h3F00F;
        a1 = 18'h00FFF; b1 = 18'h31313; c1 = 18'h1ABCD;
        commit(); tick();
    endtask

    task automatic drain();
        zero_data();
        repeat (3) begin commit(); tick(); end
    endtask

    // R1: reset state.
    task automatic t_reset();
        check64("R1 reset result", result, 64'd0);
        check64("R1 reset casc_out", casc_out, 64'd0);
    endtask

    // R2: three-edge latency and cascade output mirror.
    task automatic t_latency();
        cfg(0, 0, 0, 0, 1, 1, 1); casc_in = 0; clear_run();
        a0 = 9; b0 = 1; c0 = 3;
        @(posedge clk); @(negedge clk);
        zero_data();
        @(posedge clk); @(negedge clk);
        check64("R2 not yet after two edges", result, 64'd0);
        @(posedge clk); @(negedge clk);
        check64("R2 result after three edges", result, 64'd30);
        check64("R2 casc_out mirrors result", casc_out, 64'd30);
    endtask

    // R3 and R5: dual lanes, sum and difference, pre-add and pre-subtract.
    task automatic t_dual();
        cfg(0, 0, 0, 0, 1, 1, 1); casc_in = 0; clear_run(); cur_req = "R3 dual sum";
        dsmp(100, 18'h3FFFD, 7, 18'h3FFFB, 20, 18'h3FFF7, 0);
        dsmp(18'h20000, 18'h20000, 18'h20000, 18'h1FFFF, 18'h1FFFF, 18'h1FFFF, 0);
        dsmp(1234, 567, 18'h3FC18, 42, 7, 99, 1);
        drain();
        cfg(0, 0, 1, 0, 1, 1, 1); clear_run(); cur_req = "R3 R5 dual diff presub";
        dsmp(500, 200, 11, 18'h3FF00, 300, 13, 1);
        dsmp(18'h20000, 18'h1FFFF, 18'h1FFFF, 5, 18'h20000, 18'h20000, 1);
        drain();
        cfg(0, 0, 0, 0, 0, 1, 1); clear_run(); cur_req = "R5 pre-adder off b ignored";
        dsmp(77, 18'h2ABCD, 3, 18'h3FFFE, 18'h15555, 9, 1);
        dsmp(18'h20000, 18'h1FFFF, 18'h1FFFF, 1, 18'h3FFFF, 18'h20000, 0);
        drain();
    endtask

    // R4 and R7: wide mode signed extremes and unsigned extremes.
    task automatic t_wide();
        cfg(1, 0, 0, 0, 1, 1, 1); casc_in = 0; clear_run(); cur_req = "R4 wide signed";
        wsmp(26'h2000000, 26'h2000000, 27'h4000000, 0);
        wsmp(26'd123456, 26'h3FFFF00, 27'd98765, 1);
        wsmp(26'h1FFFFFF, 26'h1FFFFFF, 27'h3FFFFFF, 0);
        drain();
        cfg(1, 0, 0, 0, 1, 0, 0); clear_run(); cur_req = "R7 wide unsigned";
        wsmp(26'h3FFFFFF, 26'h3FFFFFF, 27'h7FFFFFF, 0);
        wsmp(26'h2000000, 26'd5, 27'h4000000, 1);
        drain();
    endtask

    // R7: dual lanes unsigned, and signed operands with unsigned coefficient.
    task automatic t_unsigned();
        cfg(0, 0, 0, 0, 1, 0, 0); casc_in = 0; clear_run(); cur_req = "R7 dual unsigned";
        dsmp(18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h20000, 1, 18'h20000, 0);
        drain();
        cfg(0, 0, 0, 0, 1, 1, 0); clear_run(); cur_req = "R7 signed data unsigned coef";
        dsmp(18'h3FFFF, 0, 18'h3FFFF, 18'h20000, 0, 2, 0);
        drain();
    endtask

    // R6: coefficient bank in both modes, live coefficient ignored.
    task automatic t_bank();
        cfg(0, 0, 0, 0, 1, 1, 1); casc_in = 0; clear_run(); cur_req = "R6 bank dual";
        coef_use = 2'b11; coef_sel0 = 1; coef_sel1 = 4;
        dsmp(100, 1, 18'h12345, 7, 3, 18'h2AAAA, 0);
        coef_sel0 = 6; coef_sel1 = 2;
        dsmp(18'h3FF00, 50, 999, 11, 11, 5, 1);
        coef_use = 2'b10; coef_sel1 = 0;
        dsmp(20, 0, 9, 4, 0, 18'h3FFFF, 0);
        drain();
        cfg(1, 0, 0, 0, 1, 1, 1); clear_run(); cur_req = "R6 bank wide";
        coef_use = 2'b01; coef_sel0 = 2;
        wsmp(26'd1000, 26'd24, 27'd17, 0);
        coef_sel0 = 6;
        wsmp(26'h3FFFFF0, 26'd1, 27'd0, 1);
        coef_sel0 = 4;
        wsmp(26'd3, 26'd0, 27'h7FFFFFF, 0);
        drain();
    endtask

    // R8 and R10: accumulate with load, cascade add and 64-bit wrap.
    task automatic t_accum();
        cfg(0, 0, 0, 0, 1, 1, 1); casc_in = 64'd1000; clear_run(); cur_req = "R8 R10 accumulate";
        acc_en = 1; acc_load = 1;
        dsmp(10, 2, 3, 1, 1, 5, 0);
        acc_load = 0;
        dsmp(18'h3FFF0, 0, 7, 4, 4, 4, 0);
        dsmp(1000, 1000, 1000, 0, 0, 0, 1);
        acc_load = 1;
        dsmp(5, 5, 5, 6, 6, 6, 0);
        acc_load = 0;
        dsmp(18'h20000, 18'h20000, 18'h20000, 9, 9, 9, 0);
        drain();
        casc_in = 64'h7FFF_FFFF_FFFF_FF00; clear_run(); cur_req = "R8 wrap 64";
        acc_en = 1; acc_load = 1;
        dsmp(1, 0, 1, 0, 0, 0, 0);
        acc_load = 0;
        dsmp(1, 0, 1, 0, 0, 0, 0);
        dsmp(1, 0, 1, 0, 0, 0, 0);
        dsmp(1, 0, 1, 0, 0, 0, 0);
        drain();
    endtask

    // R9: split halves accumulate separately, low half wraps without carry.
    task automatic t_split();
        cfg(0, 1, 0, 0, 1, 1, 1); casc_in = {32'd7, 32'hFFFF_FFF0}; clear_run();
        cur_req = "R9 split halves";
        acc_en = 1; acc_load = 1;
        dsmp(18'h1FFFF, 18'h1FFFF, 18'h1FFFF, 18'h3FFFF, 0, 100, 0);
        acc_load = 0;
        dsmp(18'h1FFFF, 18'h1FFFF, 18'h1FFFF, 18'h3FFFF, 0, 100, 0);
        dsmp(18'h20000, 18'h20000, 18'h1FFFF, 3, 0, 18'h3FFFF, 0);
        dsmp(18'h1FFFF, 0, 18'h1FFFF, 18'h20000, 18'h20000, 18'h20000, 0);
        drain();
    endtask

    // R10: cascade timing with and without the systolic register.
    task automatic t_casc();
        cfg(0, 0, 0, 0, 1, 1, 1); casc_in = 0; clear_run();
        repeat (3) begin @(posedge clk); @(negedge clk); end
        casc_in = 64'hDEAD_BEEF_0000_1234;
        @(posedge clk); @(negedge clk);
        check64("R10 direct cascade after one edge", result, 64'hDEAD_BEEF_0000_1234);
        cfg(0, 0, 0, 1, 1, 1, 1); casc_in = 0; clear_run();
        repeat (3) begin @(posedge clk); @(negedge clk); end
        casc_in = 64'h0123_4567_89AB_CDEF;
        @(posedge clk); @(negedge clk);
        check64("R10 systolic not after one edge", result, 64'd0);
        @(posedge clk); @(negedge clk);
        check64("R10 systolic after two edges", result, 64'h0123_4567_89AB_CDEF);
        sys_en = 0; casc_in = 0;
    endtask

    // R11 and R1: enable freezes the pipe, clear overrides a low enable.
    task automatic t_enable();
        cfg(0, 0, 0, 0, 1, 1, 1); casc_in = 0; clear_run();
        a0 = 9; b0 = 1; c0 = 3;
        @(posedge clk); @(negedge clk);
        en = 0; a0 = 18'h1FFFF; b0 = 18'h1FFFF; c0 = 18'h1FFFF; acc_en = 1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); @(negedge clk);
            check64("R11 held while enable low", result, 64'd0);
        end
        en = 1; zero_data();
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check64("R11 held sample resumes", result, 64'd30);
        en = 0; clr = 1;
        @(posedge clk); @(negedge clk);
        check64("R1 clear with enable low", result, 64'd0);
        clr = 0; en = 1;
    endtask

    initial begin
        rst_n = 0; clr = 0; en = 1; casc_in = 0;
        cfg(0, 0, 0, 0, 1, 1, 1); zero_data(); m_acc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_dual();
        t_wide();
        t_unsigned();
        t_bank();
        t_accum();
        t_split();
        t_casc();
        t_enable();
        summary();
    end
endmodule